// File: doc/BRIEF.md
# Modulo 2^N+1 Radix-4 Recoded Multiplier

This block multiplies two residues modulo 2^N+1 and returns their product as a residue of the same modulus. Both operands arrive in ordinary weighted binary, each N+1 bits wide, and each covers the full residue range 0 to 2^N. The multiplier operand is recoded into radix-4 signed digits. Every digit selects a rotated and selectively inverted copy of the multiplicand, so each partial product is already folded into the modulus. A single extra row collects the constant offsets that this folding leaves behind.

The N/2+2 rows go into a chain of carry-save stages. In each stage, the carry leaving the top bit is inverted and returned to bit 0. A closing adder in diminished-one style turns the two remaining vectors into the residue. Operands equal to 2^N, which stand for -1, bypass the recoded path and are resolved by negation. The result is optionally captured in an output register.

Top module: `modmul_booth`

## Requirements
- R1: With REG_OUT=1, prod equals (opA·opB) mod (2^N+1) one clock after the operands are sampled. With REG_OUT=0 it equals that residue in the same cycle.
- R2: prod never exceeds 2^N.
- R3: When one operand is 2^N and the other lies in 1..2^N-1, prod is 2^N+1 minus that other operand.
- R4: When both operands are 2^N, prod is 1.
- R5: When either operand is 0, prod is 0. This includes the case where the other operand is 2^N.
- R6: While rstN is low, prod is 0 whatever the operands are.
- R7: A multiplier with runs of ones (negative recoded digits) gives the exact residue. In particular, opB = 2^N-1 gives (-2·opA) mod (2^N+1).
- R8: Swapping opA and opB leaves prod unchanged.
- R9: The width parameter N takes any even value of 4 or more. R1 holds for every legal operand pair at N=4, and for sampled pairs at N=8 and N=16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| opA | input | N+1 | Multiplicand residue, 0..2^N |
| opB | input | N+1 | Multiplier residue, 0..2^N, recoded into radix-4 digits |
| prod | output | N+1 | Product residue modulo 2^N+1 |

## Verification
The hardest case to reach from the ports is a multiplier whose digit pattern drives the accumulated correction row to exactly 2^N. An N-bit row cannot hold that value, so the closing adder must drop its end-around increment instead. Which multipliers do this cannot be read off their bits. The bench therefore runs every operand pair at N=4, which covers all such patterns, and then adds seeded random pairs at N=8 and N=16. It weights the random draws toward 0 and 2^N, and adds directed all-ones and alternating multipliers to force negative digits.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  // Output source chosen by the operand classifier
  typedef enum logic [1:0] {
    OUT_CORE  = 2'd0,  // recoded datapath result
    OUT_NEG_A = 2'd1,  // opB is 2^N: result is -opA
    OUT_NEG_B = 2'd2,  // opA is 2^N: result is -opB
    OUT_ONE   = 2'd3   // both are 2^N: (-1)(-1) = 1
  } outSel_e;

  typedef struct packed {
    outSel_e outSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/mbm_ctrl.sv
module mbm_ctrl
  import mbm_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N:0]   opA,
  input  logic [N:0]   opB,
  output ctrlStrobe_t  strobe
);
  logic aMax, bMax, aNonZero, bNonZero;

  assign aMax     = opA[N];
  assign bMax     = opB[N];
  assign aNonZero = |opA;
  assign bNonZero = |opB;

  always_comb begin
    strobe.outSel = OUT_CORE;
    if (aMax && bMax)          strobe.outSel = OUT_ONE;
    else if (aMax && bNonZero) strobe.outSel = OUT_NEG_B;
    else if (bMax && aNonZero) strobe.outSel = OUT_NEG_A;
  end
endmodule

// File: rtl/mbm_booth_row.sv
// One radix-4 digit: folded partial product plus its constant offset.
module mbm_booth_row #(
  parameter int N   = 8,
  parameter int IDX = 0
) (
  input  logic [N-1:0] mcand,
  input  logic [2:0]   triple,
  output logic [N-1:0] row,
  output logic [N:0]   corr
);
  localparam longint unsigned MODL = (64'd1 << N) + 64'd1;
  localparam int KLO = 2 * IDX;
  localparam int KHI = (2 * IDX + 1 > N) ? N : 2 * IDX + 1;
  // positive digit: offset -(2^k-1); negative digit: offset 2^k+1
  localparam logic [N:0] POS_LO = (N+1)'((MODL - ((64'd1 << KLO) - 64'd1)) % MODL);
  localparam logic [N:0] POS_HI = (N+1)'((MODL - ((64'd1 << KHI) - 64'd1)) % MODL);
  localparam logic [N:0] NEG_LO = (N+1)'(((64'd1 << KLO) + 64'd1) % MODL);
  localparam logic [N:0] NEG_HI = (N+1)'(((64'd1 << KHI) + 64'd1) % MODL);

  logic one, two, neg;
  logic [N-1:0] picked, wLo, wHi, w;

  assign one = triple[1] ^ triple[0];
  assign two = (triple[2] & ~triple[1] & ~triple[0]) | (~triple[2] & triple[1] & triple[0]);
  assign neg = triple[2] & ~(triple[1] & triple[0]);

  assign picked = (one | two) ? mcand : '0;
  // multiply by 2^k modulo 2^N+1: wrapped bits come back inverted
  assign wLo = (picked << KLO) | (~picked >> (N - KLO));
  assign wHi = (picked << KHI) | (~picked >> (N - KHI));
  assign w   = two ? wHi : wLo;
  assign row = neg ? ~w : w;
  assign corr = neg ? (two ? NEG_HI : NEG_LO) : (two ? POS_HI : POS_LO);
endmodule

// File: rtl/mbm_csa_eac.sv
// 3:2 compressor whose top carry re-enters bit 0 inverted.
module mbm_csa_eac #(
  parameter int N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic [N-1:0] z,
  output logic [N-1:0] s,
  output logic [N-1:0] c
);
  logic [N-1:0] maj;
  assign s   = x ^ y ^ z;
  assign maj = (x & y) | (x & z) | (y & z);
  assign c   = {maj[N-2:0], ~maj[N-1]};
endmodule

// File: rtl/mbm_dim1_add.sv
// Closing modular adder: the inverted carry-out becomes the carry-in.
module mbm_dim1_add #(
  parameter int N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         plusOne,
  output logic [N:0]   sum
);
  logic [N:0] t;
  assign t = {1'b0, x} + {1'b0, y};

  always_comb begin
    if (plusOne)
      sum = t[N] ? {1'b0, t[N-1:0]} : t + (N+1)'(1);
    else
      sum = (t[N] && (t[N-1:0] != '0)) ? {1'b0, t[N-1:0] - N'(1)} : t;
  end
endmodule

// File: rtl/mbm_datapath.sv
module mbm_datapath
  import mbm_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N:0]  opA,
  input  logic [N:0]  opB,
  input  ctrlStrobe_t strobe,
  output logic [N:0]  prodComb
);
  localparam int ROWS  = N / 2 + 1;
  localparam int TERMS = ROWS + 1;
  localparam int CSAS  = TERMS - 2;
  localparam longint unsigned MODL = (64'd1 << N) + 64'd1;
  localparam logic [N:0]   MODV = (N+1)'(MODL);
  localparam logic [N+1:0] MODW = {1'b0, MODV};
  // each compressor adds +1 and the closing adder another +1: pre-subtract them
  localparam logic [N+1:0] ACC_INIT = (N+2)'(MODL - longint'(CSAS + 1));

  logic [N+2:0]  bExt;
  logic [N-1:0]  rowW  [ROWS];
  logic [N:0]    corrI [ROWS];
  logic [N-1:0]  terms [TERMS];
  logic [N-1:0]  sumV  [CSAS+1];
  logic [N-1:0]  carV  [CSAS+1];
  logic [N+1:0]  corrAcc;
  logic          corrWrap;
  logic [N:0]    coreRes;

  assign bExt = {2'b00, opB[N-1:0], 1'b0};

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    mbm_booth_row #(.N(N), .IDX(i)) u_row (
      .mcand  (opA[N-1:0]),
      .triple (bExt[2*i+2:2*i]),
      .row    (rowW[i]),
      .corr   (corrI[i])
    );
    assign terms[i] = rowW[i];
  end

  // offsets depend on the multiplier only, so this sum runs beside the rows
  always_comb begin
    corrAcc = ACC_INIT;
    for (int j = 0; j < ROWS; j++) begin
      corrAcc = corrAcc + {1'b0, corrI[j]};
      if (corrAcc >= MODW) corrAcc = corrAcc - MODW;
    end
  end

  // 2^N does not fit the N-bit row: emit 0 and drop the closing increment
  assign corrWrap     = corrAcc[N];
  assign terms[ROWS]  = corrWrap ? '0 : corrAcc[N-1:0];

  assign sumV[0] = terms[0];
  assign carV[0] = terms[1];
  for (genvar j = 0; j < CSAS; j++) begin : g_csa
    mbm_csa_eac #(.N(N)) u_csa (
      .x (sumV[j]),
      .y (carV[j]),
      .z (terms[j+2]),
      .s (sumV[j+1]),
      .c (carV[j+1])
    );
  end

  mbm_dim1_add #(.N(N)) u_add (
    .x       (sumV[CSAS]),
    .y       (carV[CSAS]),
    .plusOne (~corrWrap),
    .sum     (coreRes)
  );

  always_comb begin
    unique case (strobe.outSel)
      OUT_ONE:   prodComb = (N+1)'(1);
      OUT_NEG_B: prodComb = MODV - opB;
      OUT_NEG_A: prodComb = MODV - opA;
      default:   prodComb = coreRes;
    endcase
  end
endmodule

// File: rtl/modmul_booth.sv
module modmul_booth
  import mbm_pkg::*;
#(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [N:0] opA,
  input  logic [N:0] opB,
  output logic [N:0] prod
);
  ctrlStrobe_t strobe;
  logic [N:0]  prodComb;

  mbm_ctrl #(.N(N)) u_ctrl (
    .opA    (opA),
    .opB    (opB),
    .strobe (strobe)
  );

  mbm_datapath #(.N(N)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .strobe   (strobe),
    .prodComb (prodComb)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) prod <= '0;
      else       prod <= prodComb;
    end
  end else begin : g_comb
    assign prod = prodComb;
  end
endmodule

// File: rtl/modmul_booth_chk.sv
module modmul_booth_chk #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic       clk,
  input logic       rstN,
  input logic [N:0] opA,
  input logic [N:0] opB,
  input logic [N:0] prod
);
  localparam logic [N:0] TOPV = {1'b1, {N{1'b0}}};
  localparam logic [N:0] MODV = {1'b1, {(N-1){1'b0}}, 1'b1};

  AST_RES_RANGE: assert property (@(posedge clk) disable iff (!rstN) prod <= TOPV); // R2

  if (REG_OUT) begin : g_seq
    AST_UNIT_PASS: assert property (@(posedge clk) disable iff (!rstN)
      opA == 1 |=> prod == $past(opB)); // R1
    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rstN)
      (opA == 0 || opB == 0) |=> prod == 0); // R5
    AST_BOTH_MAX: assert property (@(posedge clk) disable iff (!rstN)
      (opA == TOPV && opB == TOPV) |=> prod == 1); // R4
    AST_MAX_NEGATES: assert property (@(posedge clk) disable iff (!rstN)
      (opA == TOPV && opB != 0 && opB != TOPV) |=> prod == MODV - $past(opB)); // R3
  end else begin : g_cmb
    AST_UNIT_PASS: assert property (@(posedge clk) disable iff (!rstN)
      opA == 1 |-> prod == opB); // R1
    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rstN)
      (opA == 0 || opB == 0) |-> prod == 0); // R5
    AST_BOTH_MAX: assert property (@(posedge clk) disable iff (!rstN)
      (opA == TOPV && opB == TOPV) |-> prod == 1); // R4
    AST_MAX_NEGATES: assert property (@(posedge clk) disable iff (!rstN)
      (opA == TOPV && opB != 0 && opB != TOPV) |-> prod == MODV - opB); // R3
  end
endmodule

bind modmul_booth modmul_booth_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk  (clk),
  .rstN (rstN),
  .opA  (opA),
  .opB  (opB),
  .prod (prod)
);

// File: tb/sim_modmul_booth.sv
module sim_modmul_booth;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [8:0]  a8 = '0,  b8 = '0,  p8;
  logic [4:0]  a4 = '0,  b4 = '0,  p4;
  logic [16:0] a16 = '0, b16 = '0, p16;

  modmul_booth #(.N(8))  u0 (.clk(clk), .rstN(rstN), .opA(a8),  .opB(b8),  .prod(p8));
  modmul_booth #(.N(4))  u1 (.clk(clk), .rstN(rstN), .opA(a4),  .opB(b4),  .prod(p4));
  modmul_booth #(.N(16)) u2 (.clk(clk), .rstN(rstN), .opA(a16), .opB(b16), .prod(p16));

  int checks = 0;
  int fails  = 0;

  function automatic longint unsigned refMul(longint unsigned x, longint unsigned y, int n);
    longint unsigned m;
    m = (64'd1 << n) + 64'd1;
    return (x * y) % m;
  endfunction

  task automatic expectEq(string tag, int n, longint unsigned a, longint unsigned b,
                          longint unsigned got, longint unsigned exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s n=%0d a=%0d b=%0d actual=%0d expected=%0d", tag, n, a, b, got, exp);
    end
  endtask

  // drive at a falling edge, result registered at the rising edge, read at the next fall
  task automatic run8(longint unsigned a, longint unsigned b, output longint unsigned got);
    @(negedge clk); a8 = 9'(a); b8 = 9'(b);
    @(negedge clk); got = longint'(p8);
  endtask

  task automatic chk8(string tag, longint unsigned a, longint unsigned b);
    longint unsigned got;
    run8(a, b, got);
    expectEq(tag, 8, a, b, got, refMul(a, b, 8));
  endtask

  task automatic chk4(string tag, longint unsigned a, longint unsigned b);
    @(negedge clk); a4 = 5'(a); b4 = 5'(b);
    @(negedge clk); expectEq(tag, 4, a, b, longint'(p4), refMul(a, b, 4));
  endtask

  task automatic chk16(string tag, longint unsigned a, longint unsigned b);
    @(negedge clk); a16 = 17'(a); b16 = 17'(b);
    @(negedge clk); expectEq(tag, 16, a, b, longint'(p16), refMul(a, b, 16));
  endtask

  function automatic longint unsigned pick(int n);
    int sel;
    sel = int'($urandom_range(0, 15));
    if (sel == 0) return 0;
    if (sel == 1) return 64'd1 << n;
    if (sel == 2) return (64'd1 << n) - 1;
    return longint'($urandom_range(0, (32'd1 << n)));
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    longint unsigned g1, g2;
    void'($urandom(32'h1D2C3B4A));

    // R6: reset holds the output at zero even with live operands
    a8 = 9'd200; b8 = 9'd77; a4 = 5'd13; b4 = 5'd9; a16 = 17'd4321; b16 = 17'd999;
    repeat (3) @(negedge clk);
    expectEq("R6", 8,  200,  77,  longint'(p8),  0);
    expectEq("R6", 4,  13,   9,   longint'(p4),  0);
    expectEq("R6", 16, 4321, 999, longint'(p16), 0);
    rstN = 1'b1;

    // R5 zero operands
    chk8("R5", 0, 137);
    chk8("R5", 255, 0);
    chk8("R5", 256, 0);
    chk8("R5", 0, 256);
    // R4 and R3: operands equal to 2^N
    chk8("R4", 256, 256);
    chk8("R3", 256, 1);
    chk8("R3", 256, 100);
    chk8("R3", 37, 256);
    chk8("R3", 256, 255);
    // R7 negative recoded digits
    chk8("R7", 13, 255);
    chk8("R7", 200, 170);
    chk8("R7", 255, 255);
    chk8("R7", 99, 127);
    // R1 general, including a core result of exactly 2^N
    chk8("R1", 2, 128);
    chk8("R1", 1, 211);
    chk8("R1", 128, 128);

    // R9 exhaustive at N=4
    for (int i = 0; i <= 16; i++)
      for (int j = 0; j <= 16; j++)
        chk4("R9", longint'(i), longint'(j));

    // R1 / R2 / R8 random at N=8
    for (int k = 0; k < 1500; k++) begin
      longint unsigned ra, rb;
      ra = pick(8); rb = pick(8);
      run8(ra, rb, g1);
      expectEq("R1", 8, ra, rb, g1, refMul(ra, rb, 8));
      checks++;
      if (g1 > 256) begin
        fails++;
        $display("FAIL R2 n=8 a=%0d b=%0d actual=%0d expected<=256", ra, rb, g1);
      end
      if (k % 8 == 0) begin
        run8(rb, ra, g2);
        expectEq("R8", 8, rb, ra, g2, g1);
      end
    end

    // R9 random at N=16
    for (int k = 0; k < 1500; k++) begin
      longint unsigned ra, rb;
      ra = pick(16); rb = pick(16);
      chk16("R9", ra, rb);
    end
    chk16("R4", 65536, 65536);
    chk16("R7", 12345, 65535);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule